// File: doc/BRIEF.md
# Flash page transfer controller

This block moves whole pages between a 128-byte working RAM and a non-volatile page store of 32 pages of 128 bytes each. The store is held inside the block as an array, so the block stands alone. Three commands are supported, each naming a 5-bit page index. The first copies a stored page into the whole RAM. The second erases a page to 0xFF and then programs the whole RAM into it. The third sums the bytes of a page into an 8-bit checksum. Every command handles one byte per clock cycle. A single done pulse marks the end of each command.

When reset is released, the block runs a two-stage boot with no outside help. It first copies page 0 into RAM. It then copies the first 16-byte RAM bank into a set of 16 configuration registers. A host reaches the RAM through a linear 7-bit byte address. The upper three bits of this address select the bank and the lower four bits select the byte within the bank. Programming is allowed only while both a write-enable pin and a write-enable register bit are high. A flag marks every cycle in which the page store is touched, so that a converter result taken in that cycle can be discarded.

Top module: `flash_page_xfer`

## Requirements
- R1: While reset is held and after it is released, `busy` is high. The boot copies page 0 into all 128 RAM bytes in 128 cycles and then copies RAM bytes 0..15 into the configuration registers in 16 cycles, so `busy` falls 144 cycles after the release. Register i appears on `cfg_out[8i+7:8i]`. The boot gives no `done` pulse, and reset clears `err`.
- R2: Command code 2'b01 (load) copies the named page into all 128 RAM bytes. `busy` stays high for exactly 128 cycles. `done` is high for one cycle, the first cycle in which `busy` is low again.
- R3: Command code 2'b10 (store), when enabled, erases the named page and then programs all 128 RAM bytes into it. `busy` stays high for 256 cycles and is followed by one `done` cycle. A later load of that page gives back exactly the RAM contents.
- R4: A store issued while `wren_pin` or `wren_reg` is low leaves the page unchanged. `busy` never rises, and `done` pulses in the cycle after the command.
- R5: Command code 2'b11 (checksum) puts the modulo-256 sum of the 128 bytes of the named page on `csum`. The value is present in the `done` cycle, and `csum` changes in no other cycle.
- R6: A command (code other than 2'b00) given while `busy` is high is ignored and sets `err`. `err` stays high until reset.
- R7: `conv_discard` is high in every cycle in which the page store is read or written (boot page load, erase, program, load, checksum). It is low otherwise, including during the boot copy into the registers.
- R8: A host RAM write (`host_we`) is ignored while `busy` is high. When the block is idle, it writes `host_wdata` to the byte at `host_addr`, and `host_rdata` shows that byte without delay.
- R9: Command code 2'b00 is a no-op: no `busy`, no `done`, no `err`. Page indices 0..31 are all usable, including index 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; starts the boot |
| cmd_valid | input | 1 | Command strobe, sampled on one edge |
| cmd_op | input | 2 | 00 none, 01 load, 10 store, 11 checksum |
| cmd_page | input | 5 | Page index for the command |
| wren_pin | input | 1 | Write-enable pin |
| wren_reg | input | 1 | Write-enable register bit |
| host_we | input | 1 | Host RAM byte write |
| host_addr | input | 7 | Linear RAM address: bank in [6:4], offset in [3:0] |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | RAM byte at host_addr |
| busy | output | 1 | Boot or command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| csum | output | 8 | Result of the last checksum |
| err | output | 1 | Sticky flag: a command was dropped while busy |
| conv_discard | output | 1 | Page store touched in this cycle |
| cfg_out | output | 128 | Configuration registers, register i in bits [8i+7:8i] |

## Verification
Two events can fall in the same cycle: the last byte of a transfer and the arrival of a new command. Another pair is a host RAM write that lands while a checksum is running. The bench provokes both. It drives a load command on the final busy cycle of a checksum, and in another run it drives a load and a host write together, three cycles into a checksum. In both cases the result is judged at the ports. Exactly one `done` must occur and `busy` must stay low afterwards. `err` must be set. The RAM bytes must read back unchanged, which proves the dropped load never copied a page over them.

// File: rtl/fpx_pkg.sv
package fpx_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic [1:0] {
        OP_NONE  = 2'b00,
        OP_LOAD  = 2'b01,
        OP_STORE = 2'b10,
        OP_SUM   = 2'b11
    } op_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_BOOT_PG,
        S_BOOT_CFG,
        S_ERASE,
        S_PROG,
        S_LOAD,
        S_SUM
    } st_e;

    localparam byte_t ERASED = 8'hFF;

    function automatic logic touches_store(st_e s);
        return (s == S_BOOT_PG) || (s == S_ERASE) || (s == S_PROG) ||
               (s == S_LOAD) || (s == S_SUM);
    endfunction

    function automatic byte_t add8(byte_t a, byte_t b);
        return a + b;
    endfunction

endpackage

// File: rtl/fpx_store.sv
module fpx_store #(
    parameter int PAGES  = 32,
    parameter int PBYTES = 128,
    localparam int PW = $clog2(PAGES),
    localparam int AW = $clog2(PBYTES)
) (
    input  logic                clk,
    input  logic                we,
    input  logic [PW-1:0]       page,
    input  logic [AW-1:0]       addr,
    input  fpx_pkg::byte_t      wdata,
    output fpx_pkg::byte_t      rdata
);
    localparam int TOTAL = PAGES * PBYTES;

    fpx_pkg::byte_t mem [TOTAL];

    // Model of an erased array at power-up
    initial begin
        for (int i = 0; i < TOTAL; i++) mem[i] = fpx_pkg::ERASED;
    end

    always_ff @(posedge clk) begin
        if (we) mem[{page, addr}] <= wdata;
    end

    assign rdata = mem[{page, addr}];

endmodule

// File: rtl/fpx_ram.sv
module fpx_ram #(
    parameter int NBYTES = 128,
    localparam int AW = $clog2(NBYTES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            busy,
    input  logic            host_we,
    input  logic [AW-1:0]   host_addr,
    input  fpx_pkg::byte_t  host_wdata,
    output fpx_pkg::byte_t  host_rdata,
    input  logic            ctl_we,
    input  logic [AW-1:0]   ctl_waddr,
    input  fpx_pkg::byte_t  ctl_wdata,
    input  logic [AW-1:0]   ctl_raddr,
    output fpx_pkg::byte_t  ctl_rdata
);
    fpx_pkg::byte_t mem [NBYTES];

    always_ff @(posedge clk) begin
        if (ctl_we)                mem[ctl_waddr] <= ctl_wdata;
        else if (host_we && !busy) mem[host_addr] <= host_wdata;
    end

    assign host_rdata = mem[host_addr];
    assign ctl_rdata  = mem[ctl_raddr];

    // R8: a host write during a busy period leaves the byte as it was
    p_host_blocked_r8: assert property (@(posedge clk) disable iff (rst)
        (busy && host_we && !(ctl_we && ctl_waddr == host_addr))
        |=> mem[$past(host_addr)] == $past(mem[host_addr]));

endmodule

// File: rtl/fpx_seq.sv
module fpx_seq
    import fpx_pkg::*;
#(
    parameter int PAGES      = 32,
    parameter int PBYTES     = 128,
    parameter int BANK_BYTES = 16,
    localparam int PW = $clog2(PAGES),
    localparam int AW = $clog2(PBYTES),
    localparam int OW = $clog2(BANK_BYTES)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [1:0]      cmd_op,
    input  logic [PW-1:0]   cmd_page,
    input  logic            wren_pin,
    input  logic            wren_reg,
    output logic            nv_we,
    output logic [PW-1:0]   nv_page,
    output logic [AW-1:0]   nv_addr,
    output byte_t           nv_wdata,
    input  byte_t           nv_rdata,
    output logic            ram_we,
    output logic [AW-1:0]   ram_addr,
    output byte_t           ram_wdata,
    input  byte_t           ram_rdata,
    output logic            cfg_we,
    output logic [OW-1:0]   cfg_idx,
    output byte_t           cfg_data,
    output logic            busy,
    output logic            done,
    output byte_t           csum,
    output logic            err,
    output logic            conv_discard
);
    localparam logic [AW-1:0] LAST_BYTE = AW'(PBYTES - 1);
    localparam logic [AW-1:0] LAST_CFG  = AW'(BANK_BYTES - 1);

    st_e           state;
    logic [AW-1:0] idx;
    logic [PW-1:0] page_q;
    byte_t         acc;
    logic          accept, wr_ok, last;

    assign accept = cmd_valid && (op_e'(cmd_op) != OP_NONE);
    assign wr_ok  = wren_pin && wren_reg;
    assign last   = (idx == LAST_BYTE);
    assign busy   = (state != S_IDLE);

    assign nv_page      = page_q;
    assign nv_addr      = idx;
    assign nv_we        = (state == S_ERASE) || (state == S_PROG);
    assign nv_wdata     = (state == S_ERASE) ? ERASED : ram_rdata;
    assign ram_addr     = idx;
    assign ram_we       = (state == S_BOOT_PG) || (state == S_LOAD);
    assign ram_wdata    = nv_rdata;
    assign cfg_we       = (state == S_BOOT_CFG);
    assign cfg_idx      = idx[OW-1:0];
    assign cfg_data     = ram_rdata;
    assign conv_discard = touches_store(state);

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= S_BOOT_PG;
            idx    <= '0;
            page_q <= '0;
            acc    <= '0;
            csum   <= '0;
            done   <= 1'b0;
            err    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (busy && accept) err <= 1'b1;
            case (state)
                S_IDLE: begin
                    if (accept) begin
                        page_q <= cmd_page;
                        idx    <= '0;
                        acc    <= '0;
                        case (op_e'(cmd_op))
                            OP_LOAD:  state <= S_LOAD;
                            OP_SUM:   state <= S_SUM;
                            OP_STORE: begin
                                if (wr_ok) state <= S_ERASE;
                                else       done  <= 1'b1;
                            end
                            default:  state <= S_IDLE;
                        endcase
                    end
                end
                S_BOOT_PG: begin
                    idx <= idx + AW'(1);
                    if (last) begin
                        idx   <= '0;
                        state <= S_BOOT_CFG;
                    end
                end
                S_BOOT_CFG: begin
                    idx <= idx + AW'(1);
                    if (idx == LAST_CFG) begin
                        idx   <= '0;
                        state <= S_IDLE;
                    end
                end
                S_ERASE: begin
                    idx <= idx + AW'(1);
                    if (last) begin
                        idx   <= '0;
                        state <= S_PROG;
                    end
                end
                S_PROG, S_LOAD: begin
                    idx <= idx + AW'(1);
                    if (last) begin
                        state <= S_IDLE;
                        done  <= 1'b1;
                    end
                end
                S_SUM: begin
                    idx <= idx + AW'(1);
                    acc <= add8(acc, nv_rdata);
                    if (last) begin
                        csum  <= add8(acc, nv_rdata);
                        state <= S_IDLE;
                        done  <= 1'b1;
                    end
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    // R2: the done pulse only occurs once the block is idle again
    p_done_idle_r2: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R4: a gated store completes at once without a busy period
    p_gated_store_r4: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_valid && op_e'(cmd_op) == OP_STORE && !wr_ok)
        |=> (done && !busy));

    // R5: the checksum output moves only together with done
    p_csum_on_done_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(csum) |-> done);

    // R6: a command during a busy period raises the error flag
    p_busy_cmd_err_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && accept) |=> err);

    // R6: the error flag holds until reset
    p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        err |=> err);

    // R7: store activity is confined to busy periods
    p_conv_busy_r7: assert property (@(posedge clk) disable iff (rst)
        conv_discard |-> busy);

    // R9: a no-op command starts nothing
    p_nop_r9: assert property (@(posedge clk) disable iff (rst)
        (!busy && cmd_valid && op_e'(cmd_op) == OP_NONE) |=> (!busy && !done));

endmodule

// File: rtl/flash_page_xfer.sv
module flash_page_xfer #(
    parameter int NUM_PAGES  = 32,
    parameter int NUM_BANKS  = 8,
    parameter int BANK_BYTES = 16,
    localparam int PBYTES = NUM_BANKS * BANK_BYTES,
    localparam int PW     = $clog2(NUM_PAGES),
    localparam int AW     = $clog2(PBYTES),
    localparam int OW     = $clog2(BANK_BYTES)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cmd_valid,
    input  logic [1:0]              cmd_op,
    input  logic [PW-1:0]           cmd_page,
    input  logic                    wren_pin,
    input  logic                    wren_reg,
    input  logic                    host_we,
    input  logic [AW-1:0]           host_addr,
    input  logic [7:0]              host_wdata,
    output logic [7:0]              host_rdata,
    output logic                    busy,
    output logic                    done,
    output logic [7:0]              csum,
    output logic                    err,
    output logic                    conv_discard,
    output logic [BANK_BYTES*8-1:0] cfg_out
);
    import fpx_pkg::*;

    logic          nv_we, ram_we, cfg_we;
    logic [PW-1:0] nv_page;
    logic [AW-1:0] nv_addr, ram_addr;
    logic [OW-1:0] cfg_idx;
    byte_t         nv_wdata, nv_rdata, ram_wdata, ram_rdata, cfg_data;
    byte_t         cfg_q [BANK_BYTES];

    fpx_seq #(.PAGES(NUM_PAGES), .PBYTES(PBYTES), .BANK_BYTES(BANK_BYTES)) u_seq (
        .clk(clk), .rst(rst),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_page(cmd_page),
        .wren_pin(wren_pin), .wren_reg(wren_reg),
        .nv_we(nv_we), .nv_page(nv_page), .nv_addr(nv_addr),
        .nv_wdata(nv_wdata), .nv_rdata(nv_rdata),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .ram_rdata(ram_rdata),
        .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_data(cfg_data),
        .busy(busy), .done(done), .csum(csum), .err(err),
        .conv_discard(conv_discard)
    );

    fpx_store #(.PAGES(NUM_PAGES), .PBYTES(PBYTES)) u_store (
        .clk(clk), .we(nv_we), .page(nv_page), .addr(nv_addr),
        .wdata(nv_wdata), .rdata(nv_rdata)
    );

    fpx_ram #(.NBYTES(PBYTES)) u_ram (
        .clk(clk), .rst(rst), .busy(busy),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata),
        .ctl_we(ram_we), .ctl_waddr(ram_addr), .ctl_wdata(ram_wdata),
        .ctl_raddr(ram_addr), .ctl_rdata(ram_rdata)
    );

    generate
        for (genvar g = 0; g < BANK_BYTES; g++) begin : g_cfg
            always_ff @(posedge clk) begin
                if (rst)                                 cfg_q[g] <= '0;
                else if (cfg_we && cfg_idx == OW'(g))    cfg_q[g] <= cfg_data;
            end
            assign cfg_out[g*8 +: 8] = cfg_q[g];
        end
    endgenerate

endmodule

// File: tb/flash_page_xfer_bench.sv
module flash_page_xfer_bench;

    logic         clk = 1'b0;
    logic         rst;
    logic         cmd_valid, wren_pin, wren_reg, host_we;
    logic [1:0]   cmd_op;
    logic [4:0]   cmd_page;
    logic [6:0]   host_addr;
    logic [7:0]   host_wdata, host_rdata, csum;
    logic         busy, done, err, conv_discard;
    logic [127:0] cfg_out;

    always #2 clk = ~clk;

    flash_page_xfer u_flash_page_xfer (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_page(cmd_page), .wren_pin(wren_pin), .wren_reg(wren_reg),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_rdata(host_rdata), .busy(busy), .done(done), .csum(csum),
        .err(err), .conv_discard(conv_discard), .cfg_out(cfg_out)
    );

    int n_run  = 0;
    int n_fail = 0;

    typedef struct { int op; logic [7:0] sum; } exp_t;
    exp_t exp_q[$];

    logic [7:0] ram_m [128];
    logic [7:0] nv_m  [32][128];

    task automatic chk(bit ok, string req, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: every done pulse must match the next expected item
    always @(negedge clk) begin
        if (!rst && done) begin
            if (exp_q.size() == 0) begin
                chk(1'b0, "R2 unexpected done pulse", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.op == 3) chk(csum == e.sum, "R5 checksum", csum, e.sum);
                else           chk(1'b1, "R2 done pulse", 1, 1);
            end
        end
    end

    task automatic host_wr(input logic [6:0] a, input logic [7:0] d);
        if (!busy) ram_m[a] = d;
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic fill_ram(input int mul, input int add);
        for (int i = 0; i < 128; i++) host_wr(7'(i), 8'(i * mul + add));
    endtask

    task automatic verify_ram(input string req);
        int bad = 0;
        int first = -1;
        for (int i = 0; i < 128; i++) begin
            host_addr = 7'(i);
            #0.1;
            if (host_rdata !== ram_m[i]) begin
                bad++;
                if (first < 0) first = i;
            end
        end
        chk(bad == 0, req, bad, 0);
    endtask

    function automatic logic [7:0] page_sum(input int p);
        logic [7:0] s = 8'h00;
        for (int i = 0; i < 128; i++) s = s + nv_m[p][i];
        return s;
    endfunction

    // Driver: issue a command, model it, push the expectation, time the busy period
    task automatic run_cmd(input int op, input int p, input int exp_busy, input string req);
        int   nb = 0;
        int   nc = 0;
        exp_t e;
        e.op = op; e.sum = 8'h00;
        if (op == 1) for (int i = 0; i < 128; i++) ram_m[i] = nv_m[p][i];
        if (op == 2 && wren_pin && wren_reg) for (int i = 0; i < 128; i++) nv_m[p][i] = ram_m[i];
        if (op == 3) e.sum = page_sum(p);
        if (op != 0) exp_q.push_back(e);
        cmd_valid = 1'b1; cmd_op = 2'(op); cmd_page = 5'(p);
        @(negedge clk);
        cmd_valid = 1'b0;
        while (busy) begin
            nb++;
            if (conv_discard) nc++;
            @(negedge clk);
        end
        chk(nb == exp_busy, {req, " busy length"}, nb, exp_busy);
        chk(nc == exp_busy, "R7 discard flag during store access", nc, exp_busy);
        chk(done == (op != 0), {req, " done after busy"}, done, op != 0);
        @(negedge clk);
    endtask

    task automatic boot(input string req);
        int nb = 0;
        int nc = 0;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk(busy == 1'b1 && done == 1'b0 && err == 1'b0, "R1 state in reset",
            {busy, done, err}, 3'b100);
        rst = 1'b0;
        while (busy) begin
            nb++;
            if (conv_discard) nc++;
            chk(done == 1'b0, "R1 no done during boot", done, 0);
            @(negedge clk);
        end
        chk(nb == 144, {req, " boot length"}, nb, 144);
        chk(nc == 128, "R7 discard only during page load of boot", nc, 128);
        for (int i = 0; i < 128; i++) ram_m[i] = nv_m[0][i];
    endtask

    task automatic verify_cfg(input string req);
        int bad = 0;
        for (int i = 0; i < 16; i++)
            if (cfg_out[i*8 +: 8] !== ram_m[i]) bad++;
        chk(bad == 0, req, bad, 0);
    endtask

    initial begin
        rst = 1'b1; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_page = '0;
        wren_pin = 1'b1; wren_reg = 1'b1;
        host_we = 1'b0; host_addr = '0; host_wdata = '0;
        for (int p = 0; p < 32; p++)
            for (int i = 0; i < 128; i++) nv_m[p][i] = 8'hFF;

        // R1: boot from an erased store
        boot("R1");
        verify_ram("R1 boot copies page 0 into RAM");
        verify_cfg("R1 boot copies bank 0 into registers");

        // R8: host access while idle, bank/offset address split
        fill_ram(7, 3);
        host_wr({3'd2, 4'd5}, 8'hC3);
        verify_ram("R8 idle host writes land");

        // R3: store page 5, then load it back over different RAM data
        run_cmd(2, 5, 256, "R3 store");
        fill_ram(13, 1);
        run_cmd(1, 5, 128, "R2 load");
        verify_ram("R3 page content equals stored RAM");

        // R3: storing over an already programmed page replaces it
        fill_ram(5, 200);
        run_cmd(2, 5, 256, "R3 restore");
        fill_ram(1, 0);
        run_cmd(1, 5, 128, "R2 load after rewrite");
        verify_ram("R3 second store replaces page");

        // R5: checksums of a programmed and an erased page
        run_cmd(3, 5, 128, "R5 sum page 5");
        run_cmd(3, 9, 128, "R5 sum erased page");
        chk(csum == 8'h80, "R5 erased page sums to 0x80", csum, 8'h80);

        // R4: blocked stores (pin low, then register bit low)
        fill_ram(3, 77);
        wren_pin = 1'b0;
        run_cmd(2, 5, 0, "R4 store with pin low");
        wren_pin = 1'b1; wren_reg = 1'b0;
        run_cmd(2, 5, 0, "R4 store with bit low");
        wren_reg = 1'b1;
        run_cmd(1, 5, 128, "R4 load after blocked stores");
        verify_ram("R4 page unchanged by blocked stores");

        // R9: no-op command and the highest page index
        cmd_valid = 1'b1; cmd_op = 2'b00;
        @(negedge clk);
        cmd_valid = 1'b0;
        chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R9 no-op starts nothing",
            {busy, done, err}, 0);
        fill_ram(11, 9);
        run_cmd(2, 31, 256, "R9 store page 31");
        fill_ram(1, 1);
        run_cmd(1, 31, 128, "R9 load page 31");
        verify_ram("R9 page 31 round trip");

        // R6/R8: load and host write together, three cycles into a checksum
        begin
            exp_t e;
            e.op = 3; e.sum = page_sum(5);
            exp_q.push_back(e);
            cmd_valid = 1'b1; cmd_op = 2'b11; cmd_page = 5'd5;
            @(negedge clk);
            cmd_valid = 1'b0;
            repeat (3) @(negedge clk);
            cmd_valid = 1'b1; cmd_op = 2'b01; cmd_page = 5'd9;
            host_wr(7'd10, 8'h5A);
            cmd_valid = 1'b0;
            chk(err == 1'b1, "R6 err after command while busy", err, 1);
            while (busy) @(negedge clk);
            @(negedge clk);
            chk(busy == 1'b0, "R6 dropped load did not start", busy, 0);
            verify_ram("R8 RAM untouched by busy host write and dropped load");
        end

        // R6: command on the final busy cycle of a checksum
        begin
            exp_t e;
            int   nb = 0;
            e.op = 3; e.sum = page_sum(9);
            exp_q.push_back(e);
            cmd_valid = 1'b1; cmd_op = 2'b11; cmd_page = 5'd9;
            @(negedge clk);
            cmd_valid = 1'b0;
            while (nb < 127) begin nb++; @(negedge clk); end
            chk(busy == 1'b1, "R2 still busy on 128th cycle", busy, 1);
            cmd_valid = 1'b1; cmd_op = 2'b01; cmd_page = 5'd9;
            @(negedge clk);
            cmd_valid = 1'b0;
            chk(busy == 1'b0 && done == 1'b1, "R6 transfer ends normally",
                {busy, done}, 2'b01);
            @(negedge clk);
            chk(busy == 1'b0, "R6 last-cycle command ignored", busy, 0);
            chk(err == 1'b1, "R6 err stays set", err, 1);
            verify_ram("R6 RAM untouched by last-cycle command");
        end

        // R1: store a pattern in page 0 and boot again
        fill_ram(17, 4);
        run_cmd(2, 0, 256, "R3 store page 0");
        fill_ram(0, 0);
        boot("R1 second");
        chk(err == 1'b0, "R1 reset clears err", err, 0);
        verify_ram("R1 reboot loads stored page 0");
        verify_cfg("R1 reboot loads bank 0 into registers");
        chk(exp_q.size() == 0, "R2 every expected done seen", exp_q.size(), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule